// File: doc/BRIEF.md
# Parallel Bus Cycle Master

This block runs bus cycles on a classical single-master parallel system bus. A request port in the core clock domain carries an address, write data and a cycle kind. The kind is one of memory read, memory write, I/O read, I/O write or interrupt acknowledge. The block presents the address and pulses an address strobe for one clock. It then pulls exactly one active-low command line low and enables the data drivers.

The command phase has no fixed length. It lasts until the addressed slave raises Ready, so a slow slave stretches the cycle. On a read-type cycle the slave's data is captured on the clock edge that samples Ready high. After a one-clock recovery phase with every command line high, the block returns to idle. The recovery clock carries a one-clock `done` pulse together with the captured data.

A per-request timeout limit guards against a slave that never answers. When it expires, the cycle is ended and flagged as a bus error.

Top module: `bus_cycle_master`

## Requirements
- R1: `req_ready` is high only in the idle phase, and a request is taken only on a clock edge where `req_ready` and `req_valid` are both high. A request whose kind is 5, 6 or 7 is ignored: no strobe moves and the block stays idle. Kind encoding: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 interrupt acknowledge.
- R2: In the clock after acceptance, `ale` is high for exactly one cycle, `bus_addr` already shows the request address, and all five command lines and `den` are inactive.
- R3: `bus_addr` stays equal to the accepted address from the `ale` cycle through the recovery cycle. A `req_valid` raised while busy does not change it.
- R4: In the command phase exactly one command line is low, namely the one matching the kind (`mrd_n` 0, `mwr_n` 1, `iord_n` 2, `iowr_n` 3, `inta_n` 4), and `den` is high. Outside the command phase all command lines are high and `den` is low.
- R5: During the command phase of every cycle, `bus_wdata` equals the write data of the request.
- R6: The command phase lasts W+1 clocks when the slave raises `bus_ready` after W clocks of waiting.
- R7: For kinds 0, 2 and 4, `rd_data` during the `done` cycle equals the `bus_rdata` value present at the edge that sampled `bus_ready` high. For kinds 1 and 3, `rd_data` is zero.
- R8: After the command phase comes one recovery clock with `done` high and all command lines high. The next clock is idle with `done` low.
- R9: With a nonzero limit L, a command phase that sees no Ready in L clocks ends after L clocks with `bus_err` high during the `done` cycle and `rd_data` zero. Ready sampled in the L-th clock still completes normally. A limit of 0 disables the timeout.
- R10: After reset the block is idle: `req_ready` is high, `ale`, `den`, `done` and `bus_err` are low, and all command lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_kind | input | 3 | Cycle kind, 0..4 valid |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| timeout_limit | input | TW | Command-phase timeout in clocks, 0 disables |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DW | Captured read data, valid with done |
| bus_err | output | 1 | Timeout flag, valid with done |
| bus_addr | output | AW | Address lines |
| ale | output | 1 | Address latch strobe |
| den | output | 1 | Data driver enable |
| bus_wdata | output | DW | Write data lines |
| bus_rdata | input | DW | Read data lines from slave |
| bus_ready | input | 1 | Slave Ready |
| mrd_n | output | 1 | Memory read command, active low |
| mwr_n | output | 1 | Memory write command, active low |
| iord_n | output | 1 | I/O read command, active low |
| iowr_n | output | 1 | I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge command, active low |

## Verification
The bench offers a request at a falling edge. It expects `ale` at the next falling edge and the command phase from the falling edge after that. For a slave wait of W, `done` falls due W+3 falling edges after the request; for a timeout of L, it falls due L+2 edges after. The embedded slave model raises Ready at the falling edge of the W-th command clock, so the rising edge that follows samples it. Every check is made at a falling edge whose index was counted from the request, never by waiting for an output to change.

// File: rtl/bus_cycle_master.sv
module bus_cycle_master #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] timeout_limit,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          bus_err,
  output logic [AW-1:0] bus_addr,
  output logic          ale,
  output logic          den,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          mrd_n,
  output logic          mwr_n,
  output logic          iord_n,
  output logic          iowr_n,
  output logic          inta_n
);
  localparam int NKIND = 5;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_CMD, S_RCV} state_t;

  state_t          state;
  logic [2:0]      kind_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [DW-1:0]   rdata_q;
  logic [TW-1:0]   lim_q;
  logic [TW-1:0]   cnt;
  logic            err_q;
  logic [NKIND-1:0] cmd_sel;

  wire accept  = (state == S_IDLE) && req_valid && (req_kind < 3'(NKIND));
  wire is_read = (kind_q == 3'd0) || (kind_q == 3'd2) || (kind_q == 3'd4);
  wire expired = (lim_q != '0) && (cnt == lim_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      lim_q   <= '0;
      cnt     <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state   <= S_ADDR;
          kind_q  <= req_kind;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          lim_q   <= timeout_limit;
        end
        S_ADDR: begin
          state <= S_CMD;
          cnt   <= '0;
          err_q <= 1'b0;
        end
        S_CMD: begin
          if (bus_ready) begin
            state   <= S_RCV;
            rdata_q <= is_read ? bus_rdata : '0;
          end else if (expired) begin
            state   <= S_RCV;
            rdata_q <= '0;
            err_q   <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_sel   = (state == S_CMD) ? (NKIND'(1) << kind_q) : '0;
  assign {inta_n, iowr_n, iord_n, mwr_n, mrd_n} = ~cmd_sel;
  assign req_ready = (state == S_IDLE);
  assign ale       = (state == S_ADDR);
  assign den       = (state == S_CMD);
  assign done      = (state == S_RCV);
  assign bus_err   = done & err_q;
  assign rd_data   = done ? rdata_q : '0;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mrd_n, mwr_n, iord_n, iowr_n, inta_n}) >= NKIND - 1);
  p_strobe_with_den_r4: assert property (@(posedge clk) disable iff (!rst_n)
    den == ($countones({mrd_n, mwr_n, iord_n, iowr_n, inta_n}) == NKIND - 1));
  p_ale_then_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> den && !ale);
  p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (den || done) |-> $stable(bus_addr));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);
  p_done_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(den));
  p_err_only_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> done && rd_data == '0);
endmodule

// File: tb/sim_bus_cycle_master.sv
module sim_bus_cycle_master;
  localparam int AW = 16, DW = 16, TW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_kind = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [TW-1:0] timeout_limit = '0;
  logic done, bus_err, ale, den, bus_ready = 1'b0;
  logic [DW-1:0] rd_data, bus_wdata, bus_rdata = '0;
  logic [AW-1:0] bus_addr;
  logic mrd_n, mwr_n, iord_n, iowr_n, inta_n;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bus_cycle_master #(.AW(AW), .DW(DW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .timeout_limit(timeout_limit), .done(done), .rd_data(rd_data),
    .bus_err(bus_err), .bus_addr(bus_addr), .ale(ale), .den(den),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .mrd_n(mrd_n), .mwr_n(mwr_n), .iord_n(iord_n), .iowr_n(iowr_n),
    .inta_n(inta_n));

  function automatic logic [DW-1:0] slave_data(input logic [AW-1:0] a);
    return DW'(a * 3) ^ 16'hA5C3;
  endfunction

  function automatic logic [4:0] exp_strobes(input logic [2:0] k);
    return ~(5'd1 << k);
  endfunction

  function automatic bit reads(input logic [2:0] k);
    return k == 3'd0 || k == 3'd2 || k == 3'd4;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic txn(input logic [2:0] k, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                     input int wt, input int lim, input bit busy_req);
    bit err_exp = (lim != 0) && (wt >= lim);
    int ncmd = err_exp ? lim : wt + 1;
    logic [DW-1:0] rexp = (err_exp || !reads(k)) ? '0 : slave_data(a);
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready before request", 32'(req_ready), 1);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    timeout_limit = TW'(lim);
    @(negedge clk);
    if (busy_req) begin
      req_addr = ~a; req_kind = 3'd1;
    end else req_valid = 1'b0;
    check(ale && !den && bus_addr == a && !req_ready, "R2 address phase",
          {ale, den, req_ready, 13'd0, bus_addr}, {3'b100, 13'd0, a});
    check({inta_n, iowr_n, iord_n, mwr_n, mrd_n} == 5'h1f, "R2 strobes idle",
          {27'd0, inta_n, iowr_n, iord_n, mwr_n, mrd_n}, 32'h1f);
    for (int c = 0; c < ncmd; c++) begin
      @(negedge clk);
      check({inta_n, iowr_n, iord_n, mwr_n, mrd_n} == exp_strobes(k) && den && !ale,
            "R4 command strobe", {26'd0, den, inta_n, iowr_n, iord_n, mwr_n, mrd_n},
            {26'd0, 1'b1, exp_strobes(k)});
      check(bus_addr == a, "R3 address held", 32'(bus_addr), 32'(a));
      check(bus_wdata == wd, "R5 write data", 32'(bus_wdata), 32'(wd));
      check(!done, "R6 no early done", 32'(done), 0);
      bus_ready = !err_exp && (c == wt);
      bus_rdata = (c == wt) ? slave_data(a) : DW'($urandom);
    end
    @(negedge clk);
    bus_ready = 1'b0; bus_rdata = DW'($urandom);
    check(done && !den, "R6 done after command phase", {30'd0, done, den}, 32'h2);
    check({inta_n, iowr_n, iord_n, mwr_n, mrd_n} == 5'h1f, "R8 recovery strobes high",
          {27'd0, inta_n, iowr_n, iord_n, mwr_n, mrd_n}, 32'h1f);
    check(bus_addr == a, "R3 address held in recovery", 32'(bus_addr), 32'(a));
    check(rd_data == rexp, "R7 read data", 32'(rd_data), 32'(rexp));
    check(bus_err == err_exp, "R9 error flag", 32'(bus_err), 32'(err_exp));
    req_valid = 1'b0;
    @(negedge clk);
    check(!done && req_ready && !ale, "R8 back to idle", {29'd0, done, req_ready, ale}, 32'h2);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(req_ready && !ale && !den && !done && !bus_err, "R10 reset state",
          {27'd0, req_ready, ale, den, done, bus_err}, 32'h10);
    check({inta_n, iowr_n, iord_n, mwr_n, mrd_n} == 5'h1f, "R10 strobes high",
          {27'd0, inta_n, iowr_n, iord_n, mwr_n, mrd_n}, 32'h1f);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) txn(3'(k), AW'(16'h1000 + k), DW'(16'hBEE0 + k), k, 0, 0);
    txn(3'd0, 16'h2222, 16'h0, 10, 3, 0);
    txn(3'd2, 16'h3333, 16'h0, 2, 3, 0);
    txn(3'd3, 16'h4444, 16'h5555, 40, 0, 0);
    txn(3'd4, 16'h6666, 16'h0, 1, 1, 0);
    txn(3'd1, 16'h7777, 16'h8888, 3, 0, 1);
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'hDEAD;
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready && !ale && {inta_n, iowr_n, iord_n, mwr_n, mrd_n} == 5'h1f,
            "R1 invalid kind ignored", {26'd0, req_ready, ale, inta_n, iowr_n, iord_n, mwr_n, mrd_n},
            32'h5f);
      @(negedge clk);
      check(!den && !done, "R1 invalid kind no cycle", {30'd0, den, done}, 0);
    end
    for (int n = 0; n < 40; n++) begin
      int lim = ($urandom % 2) ? 0 : 2 + ($urandom % 5);
      txn(3'($urandom % 5), AW'($urandom), DW'($urandom), $urandom % 7, lim, ($urandom % 4) == 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule